// File: doc/BRIEF.md
# Host-to-Microcontroller Mailbox

This block sits between a host register bus and a small system microcontroller and carries bytes in both directions. The host writes command and argument bytes into a transmit queue. The block hands them to the microcontroller over a byte-wide valid/ready port. Bytes that the microcontroller sends back collect in a receive queue, and the host reads them out one at a time.

The host sees three 32-bit registers: an interrupt register, a data register and a status register. Status reports whether the transmit queue is empty and whether it is not full. It also reports whether the receive queue holds data and whether a received byte was lost. Each of these four conditions has a mask bit. A condition whose mask bit is 1 raises the single host interrupt line while the condition holds. The byte always travels in bits 15:8 of the data word.

Top module: `uc_mailbox`

## Requirements
- R1: After reset both queues are empty and all mask bits are 0. Status reads 0x3 (transmit empty, transmit not full), the interrupt register reads 0, `irq_o` is low and `tx_valid_o` is low.
- R2: Only word-aligned accesses (`bus_addr[1:0]` = 0) take effect. The interrupt register is at 0x00, the data register at 0x04 and the status register at 0x08. Words 0x0C to 0x1C read as zero and ignore writes. An unaligned access reads zero and changes nothing.
- R3: A write to the data register queues `bus_wdata[15:8]`. Queued bytes appear on `tx_data_o` with `tx_valid_o` high, in the order written. A byte leaves the queue on each cycle where `tx_valid_o` and `tx_ready_i` are both high.
- R4: The transmit queue holds 8 bytes. Status bit 0 is 1 when it is empty and bit 1 is 1 when it is not full. A data write while it is full is dropped.
- R5: A byte on `rx_data_i` is stored when `rx_valid_i` and `rx_ready_o` are both high. `rx_ready_o` is low while 8 bytes are held. A data-register read returns the oldest byte in bits 15:8, with all other bits 0, and removes it. Status bit 2 is 1 while received bytes are held.
- R6: A data-register read with the receive queue empty returns 0 and leaves all state unchanged.
- R7: A byte offered while the receive queue is full is dropped and sets status bit 3. The bit stays set until the host writes status with bit 3 = 1. If a drop and that write happen in the same cycle, the bit stays set.
- R8: Writing 1 to status bits 0, 1 or 2 has no effect. Those bits follow the queue state.
- R9: Interrupt register bits 7:4 are read/write masks for transmit empty, transmit not full, receive not empty and overflow, in that order. Bits 3:0 read the pending conditions (status AND mask), and writes to them are ignored. `irq_o` is high when any condition is pending.
- R10: Reads of the interrupt and status registers have no side effect on either queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Host interrupt |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Microcontroller takes the byte |
| rx_valid_i | input | 1 | Microcontroller offers a byte |
| rx_data_i | input | 8 | Offered byte |
| rx_ready_o | output | 1 | Receive queue has room |

## Verification
The assertions assume that every input is held steady from just after a rising edge until the next edge. They also assume that `bus_sel` qualifies `bus_we`, `bus_addr` and `bus_wdata`, so that a read is only seen while `bus_sel` is high. The stimulus drives every input one nanosecond after the edge and keeps it constant for the whole cycle. The microcontroller model offers bytes while `rx_ready_o` is low on purpose, to exercise the drop path. One cycle combines a drop with an overflow clear.

// File: rtl/uc_mailbox_pkg.sv
package uc_mailbox_pkg;
    localparam int unsigned REG_WORDS  = 8;
    localparam int unsigned ADDR_W     = $clog2(REG_WORDS) + 2;
    localparam int unsigned WIDX_W     = ADDR_W - 2;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned BYTE_LSB   = 8;
    localparam int unsigned Q_DEPTH    = 8;
    localparam int unsigned NCOND      = 4;

    localparam logic [WIDX_W-1:0] WIDX_INTR = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] WIDX_DATA = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] WIDX_STAT = WIDX_W'(2);

    localparam int unsigned C_TXE  = 0;
    localparam int unsigned C_TXNF = 1;
    localparam int unsigned C_RXNE = 2;
    localparam int unsigned C_RXO  = 3;

    typedef struct packed {
        logic intr_wr;
        logic stat_wr;
        logic data_wr;
        logic data_rd;
    } access_t;

    typedef struct packed {
        logic [NCOND-1:0] mask;
        logic             ovf;
    } irq_state_t;
endpackage

// File: rtl/uc_mailbox_fifo.sv
module uc_mailbox_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_push, do_pop;

    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == CNT_W'(DEPTH));
    assign pop_data = st_q.mem[st_q.rd];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(st_q.wr + 1'b1);
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(st_q.rd + 1'b1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
            2'b01:   st_d.cnt = CNT_W'(st_q.cnt - 1'b1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uc_mailbox_irq.sv
module uc_mailbox_irq
    import uc_mailbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic             rx_drop,
    input  logic             mask_we,
    input  logic [NCOND-1:0] mask_wdata,
    input  logic             clr_ovf,
    output logic [NCOND-1:0] status,
    output logic [NCOND-1:0] mask,
    output logic [NCOND-1:0] pending,
    output logic             irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        if (clr_ovf) begin
            st_d.ovf = 1'b0;
        end
        if (rx_drop) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status         = '0;
        status[C_TXE]  = tx_empty;
        status[C_TXNF] = !tx_full;
        status[C_RXNE] = !rx_empty;
        status[C_RXO]  = st_q.ovf;
    end

    assign mask = st_q.mask;

    for (genvar i = 0; i < NCOND; i++) begin : g_pend
        assign pending[i] = status[i] && st_q.mask[i];
    end

    assign irq = |pending;
endmodule

// File: rtl/uc_mailbox.sv
module uc_mailbox
    import uc_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    input  logic              tx_ready_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    output logic              rx_ready_o
);
    access_t           acc;
    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [BYTE_W-1:0] rx_head;
    logic [NCOND-1:0]  stat_vec, mask_vec, pend_vec;
    logic              unused_wbits;

    assign widx         = bus_addr[ADDR_W-1:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign unused_wbits = ^bus_wdata[BUS_W-1:BYTE_LSB+BYTE_W];

    always_comb begin
        acc         = '0;
        acc.intr_wr = bus_sel && bus_we && aligned && (widx == WIDX_INTR);
        acc.stat_wr = bus_sel && bus_we && aligned && (widx == WIDX_STAT);
        acc.data_wr = bus_sel && bus_we && aligned && (widx == WIDX_DATA);
        acc.data_rd = bus_sel && !bus_we && aligned && (widx == WIDX_DATA);
    end

    uc_mailbox_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) tx_q_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc.data_wr),
        .push_data (bus_wdata[BYTE_LSB +: BYTE_W]),
        .pop       (tx_valid_o && tx_ready_i),
        .pop_data  (tx_data_o),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uc_mailbox_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) rx_q_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid_i),
        .push_data (rx_data_i),
        .pop       (acc.data_rd),
        .pop_data  (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    uc_mailbox_irq irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_empty   (tx_empty),
        .tx_full    (tx_full),
        .rx_empty   (rx_empty),
        .rx_drop    (rx_valid_i && rx_full),
        .mask_we    (acc.intr_wr),
        .mask_wdata (bus_wdata[2*NCOND-1:NCOND]),
        .clr_ovf    (acc.stat_wr && bus_wdata[C_RXO]),
        .status     (stat_vec),
        .mask       (mask_vec),
        .pending    (pend_vec),
        .irq        (irq_o)
    );

    assign tx_valid_o = !tx_empty;
    assign rx_ready_o = !rx_full;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && aligned) begin
            case (widx)
                WIDX_INTR: bus_rdata = {{(BUS_W-2*NCOND){1'b0}}, mask_vec, pend_vec};
                WIDX_DATA: if (!rx_empty) begin
                    bus_rdata[BYTE_LSB +: BYTE_W] = rx_head;
                end
                WIDX_STAT: bus_rdata = {{(BUS_W-NCOND){1'b0}}, stat_vec};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uc_mailbox_chk.sv
module uc_mailbox_chk
    import uc_mailbox_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_ovf_bit,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic              rx_valid_i,
    input logic              rx_ready_o,
    input logic [NCOND-1:0]  status,
    input logic [NCOND-1:0]  mask
);
    logic [WIDX_W-1:0] cw;
    logic              rd_ok, ovf_clr;

    assign cw      = bus_addr[ADDR_W-1:2];
    assign rd_ok   = bus_sel && !bus_we && (bus_addr[1:0] == 2'b00);
    assign ovf_clr = bus_sel && bus_we && (bus_addr[1:0] == 2'b00) && (cw == WIDX_STAT) && wdata_ovf_bit;

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !rx_ready_o) |=> status[C_RXO]); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[C_RXO] && !ovf_clr) |=> status[C_RXO]); // R7

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && (cw == WIDX_DATA) && !status[C_RXNE]) |-> (bus_rdata == '0)); // R6

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && (cw > WIDX_STAT)) |-> (bus_rdata == '0)); // R2

    AST_TX_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        status[C_TXE] |-> !tx_valid_o); // R3

    AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[C_TXNF] && !(tx_valid_o && tx_ready_i)) |=> !status[C_TXNF]); // R4

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o); // R9
endmodule

bind uc_mailbox uc_mailbox_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .wdata_ovf_bit (bus_wdata[3]),
    .bus_rdata     (bus_rdata),
    .irq_o         (irq_o),
    .tx_valid_o    (tx_valid_o),
    .tx_ready_i    (tx_ready_i),
    .rx_valid_i    (rx_valid_i),
    .rx_ready_o    (rx_ready_o),
    .status        (stat_vec),
    .mask          (mask_vec)
);

// File: tb/uc_mailbox_tb_top.sv
module uc_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, tx_valid_o, rx_ready_o;
    logic [7:0]  tx_data_o;
    logic        tx_ready_i = 1'b0, rx_valid_i = 1'b0;
    logic [7:0]  rx_data_i = '0;

    int          n_checks = 0, n_fails = 0;
    bit          done = 1'b0;
    logic [7:0]  tx_exp[$];
    logic [7:0]  rx_exp[$];
    int          tx_level = 0;

    always #4 clk = ~clk;

    uc_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .rx_ready_o(rx_ready_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic read_expect(input logic [4:0] a, input logic [31:0] exp,
                               input string req, input string what);
        logic [31:0] v;
        bus_read(a, v);
        check(v === exp, req, what, v, exp);
    endtask

    // Driver: offers one byte from the microcontroller side and updates the model.
    task automatic mcu_send(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid_i = 1'b1; rx_data_i = b;
        @(posedge clk); #1;
        rx_valid_i = 1'b0;
        if (rx_exp.size() < 8) rx_exp.push_back(b);
    endtask

    // Host data read, compared against the receive model (R5, R6).
    task automatic host_pop(input string req);
        logic [31:0] exp;
        exp = 32'h0;
        if (rx_exp.size() > 0) exp = {16'h0, rx_exp.pop_front(), 8'h00};
        read_expect(5'h04, exp, req, "data read");
    endtask

    // Driver: host write of one byte, expected item pushed into the scoreboard.
    task automatic host_send(input logic [7:0] b);
        bus_write(5'h04, {16'hA5C3, b, 8'h5A});
        if (tx_level < 8) begin
            tx_exp.push_back(b);
            tx_level++;
        end
    endtask

    // Monitor: compares each byte taken by the microcontroller with the scoreboard (R3).
    always @(negedge clk) begin
        if (rst_n && tx_valid_o && tx_ready_i) begin
            if (tx_exp.size() == 0) begin
                check(1'b0, "R4", "unexpected tx byte", {24'h0, tx_data_o}, 32'h0);
            end else begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                check(tx_data_o === e, "R3", "tx byte order", {24'h0, tx_data_o}, {24'h0, e});
            end
            tx_level--;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(irq_o === 1'b0, "R1", "irq after reset", {31'h0, irq_o}, 32'h0);
        check(tx_valid_o === 1'b0, "R1", "tx_valid after reset", {31'h0, tx_valid_o}, 32'h0);
        read_expect(5'h08, 32'h3, "R1", "status after reset");
        read_expect(5'h00, 32'h0, "R1", "intr after reset");

        // R2: reserved words and unaligned access
        for (int a = 3; a < 8; a++) bus_write(5'(a * 4), 32'hFFFF_FFFF);
        for (int a = 3; a < 8; a++) read_expect(5'(a * 4), 32'h0, "R2", "reserved word");
        bus_write(5'h05, 32'h0000_AA00);
        @(negedge clk);
        check(tx_valid_o === 1'b0, "R2", "unaligned write queued", {31'h0, tx_valid_o}, 32'h0);
        read_expect(5'h00, 32'h0, "R2", "intr after reserved writes");
        read_expect(5'h08, 32'h3, "R10", "status unchanged by reads");

        // R6: empty read
        host_pop("R6");
        read_expect(5'h08, 32'h3, "R6", "status after empty read");

        // R9: masks and pending
        bus_write(5'h00, 32'hFF);
        read_expect(5'h00, 32'hF3, "R9", "all masks, tx conditions pending");
        check(irq_o === 1'b1, "R9", "irq with pending", {31'h0, irq_o}, 32'h1);
        bus_write(5'h00, 32'h0F);
        read_expect(5'h00, 32'h00, "R9", "request bits not writable");
        check(irq_o === 1'b0, "R9", "irq masked", {31'h0, irq_o}, 32'h0);
        bus_write(5'h00, 32'h40);
        check(irq_o === 1'b0, "R9", "irq rx mask, rx empty", {31'h0, irq_o}, 32'h0);

        // R5: receive path
        mcu_send(8'h11); mcu_send(8'h22); mcu_send(8'h33);
        @(negedge clk);
        check(irq_o === 1'b1, "R9", "irq rx not empty", {31'h0, irq_o}, 32'h1);
        read_expect(5'h00, 32'h44, "R9", "pending rx not empty");
        read_expect(5'h08, 32'h7, "R5", "status with rx data");
        read_expect(5'h08, 32'h7, "R10", "status read does not pop");
        repeat (3) host_pop("R5");
        read_expect(5'h08, 32'h3, "R5", "status after drain");
        check(irq_o === 1'b0, "R9", "irq after drain", {31'h0, irq_o}, 32'h0);

        // R7/R8: overflow
        for (int i = 0; i < 9; i++) mcu_send(8'h80 + 8'(i));
        @(negedge clk);
        check(rx_ready_o === 1'b0, "R5", "rx_ready when full", {31'h0, rx_ready_o}, 32'h0);
        read_expect(5'h08, 32'hF, "R7", "overflow set");
        bus_write(5'h08, 32'h7);
        read_expect(5'h08, 32'hF, "R8", "w1 to live bits ignored");
        bus_write(5'h08, 32'h8);
        read_expect(5'h08, 32'h7, "R7", "overflow cleared");
        repeat (9) host_pop("R7");

        // R7: drop and clear in the same cycle, set wins
        for (int i = 0; i < 8; i++) mcu_send(8'hC0 + 8'(i));
        @(posedge clk); #1;
        rx_valid_i = 1'b1; rx_data_i = 8'hEE;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h8;
        @(posedge clk); #1;
        rx_valid_i = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        read_expect(5'h08, 32'hF, "R7", "set wins over clear");
        bus_write(5'h08, 32'h8);
        repeat (9) host_pop("R7");
        read_expect(5'h08, 32'h3, "R7", "clean after drain");

        // R3/R4: transmit path, fill past full with consumer stalled
        for (int i = 0; i < 9; i++) host_send(8'h40 + 8'(i));
        read_expect(5'h08, 32'h0, "R4", "tx full status");
        @(posedge clk); #1 tx_ready_i = 1'b1;
        repeat (12) @(posedge clk);
        #1 tx_ready_i = 1'b0;
        check(tx_exp.size() == 0, "R3", "all tx bytes delivered", tx_exp.size(), 32'h0);
        read_expect(5'h08, 32'h3, "R4", "tx empty after drain");

        // R3: streaming with consumer always ready
        @(posedge clk); #1 tx_ready_i = 1'b1;
        host_send(8'hD1); host_send(8'hD2); host_send(8'hD3);
        repeat (4) @(posedge clk);
        #1 tx_ready_i = 1'b0;
        check(tx_exp.size() == 0, "R3", "streamed bytes delivered", tx_exp.size(), 32'h0);
        @(negedge clk);
        check(tx_valid_o === 1'b0, "R3", "tx idle at end", {31'h0, tx_valid_o}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule